// File: doc/BRIEF.md
# External Data Memory Access Controller

This block carries out the off-chip data memory transfers of a small 8-bit microcontroller core. The core hands over one request at a time: a direction, an address mode, an address and, for a store, the accumulator byte. The block then runs a fixed two-machine-cycle bus sequence. In the first cycle it puts the low address byte on a shared address/data port and pulses an address latch enable, so that an external latch holds that byte. In the second cycle it either reads a byte back under an active-low read strobe or drives the store byte under an active-low write strobe.

There are two address modes. A wide request uses a full 16-bit pointer, and the upper byte goes out on the high address port for the whole transfer. A narrow request uses an 8-bit pointer. In that case the high port keeps showing the general-purpose value the core last wrote to it, so software can page external memory by setting those bits. The two strobe pins are also ordinary I/O lines. They carry their general-purpose values whenever no transfer is running. The core watches `busy` and takes the loaded byte when `done` pulses.

Top module: `xmem_access_unit`

## Requirements
- R1: While reset is held and just after it, `busy`, `done`, `ale` and `adOe` are 0, `rdN` equals `rdPinIo`, `wrN` equals `wrPinIo`, and `hiOut` equals `hiPortIo`.
- R2: An accepted request keeps `busy` high for exactly 2*CLKS_PER_MCYCLE clocks (12 with defaults). `done` is high for exactly one clock, the clock right after `busy` falls.
- R3: During the first CLKS_PER_MCYCLE clocks of a transfer, `adOe` is 1 and `adOut` equals address bits 7..0. `ale` is 1 for the first CLKS_PER_MCYCLE/2 clocks and then 0 while the address is still on the port.
- R4: In a wide request (`reqWide`=1), `hiOut` equals address bits 15..8 on every clock of the transfer.
- R5: In a narrow request (`reqWide`=0), `hiOut` follows `hiPortIo` on every clock of the transfer, and address bits 15..8 have no effect.
- R6: In a read (`reqWrite`=0), `rdN` is 0 exactly on transfer clocks CLKS_PER_MCYCLE+1 through 2*CLKS_PER_MCYCLE-2 and 1 on the other transfer clocks. `adOe` is 0 for the whole second machine cycle, and `wrN` stays 1.
- R7: `rdData` takes the value of `adIn` on the last clock that `rdN` is 0. It is valid when `done` pulses and does not change until the next read finishes. Writes leave it unchanged.
- R8: In a write (`reqWrite`=1), `adOe` is 1 and `adOut` equals the request's accumulator byte through the whole second machine cycle. `wrN` is 0 exactly on transfer clocks CLKS_PER_MCYCLE+1 through 2*CLKS_PER_MCYCLE-2, and `rdN` stays 1.
- R9: When no transfer is running, `rdN` and `wrN` follow `rdPinIo` and `wrPinIo`. During a transfer those inputs have no effect on the strobe pins.
- R10: A request presented while `busy` is 1 is ignored. The running transfer keeps its address, data, direction and length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present; accepted when not busy |
| reqWrite | input | 1 | 1 = store accumulator, 0 = load accumulator |
| reqWide | input | 1 | 1 = 16-bit pointer, 0 = 8-bit pointer |
| reqAddr | input | ADDR_W (16) | Transfer address (upper byte used only when wide) |
| reqAcc | input | DATA_W (8) | Accumulator byte to store |
| hiPortIo | input | ADDR_W-DATA_W (8) | General-purpose value of the high port |
| rdPinIo | input | 1 | General-purpose value of the read strobe pin |
| wrPinIo | input | 1 | General-purpose value of the write strobe pin |
| adIn | input | DATA_W (8) | Byte seen on the shared address/data pins |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock pulse: transfer finished, read data valid |
| rdData | output | DATA_W (8) | Byte loaded for the accumulator |
| adOut | output | DATA_W (8) | Byte driven on the shared address/data pins |
| adOe | output | 1 | Output enable for the shared pins |
| ale | output | 1 | Address latch enable |
| hiOut | output | ADDR_W-DATA_W (8) | High address port pins |
| rdN | output | 1 | Active-low read strobe pin |
| wrN | output | 1 | Active-low write strobe pin |

## Verification
The hardest case to reach from the ports is a request that arrives while a transfer is already running. It has to leave address, data, direction and length untouched, and the same must hold for strobe-pin I/O values that change mid-transfer. The bench forces this by keeping `reqValid` high with inverted address, data and direction for the whole of selected transfers. It also toggles `rdPinIo` and `wrPinIo` on every clock. A bench memory model latches the low byte on the falling edge of `ale`, so wrong latch timing shows up as wrong read data or wrong store addresses. Sweeps cover every low address byte in both directions and both address modes.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;      // latch request fields
    logic inXfer;    // transfer running
    logic showAddr;  // put low address on shared port
    logic showData;  // put store byte on shared port
    logic ale;       // address latch enable
    logic rdAct;     // read strobe window
    logic wrAct;     // write strobe window
    logic capture;   // sample shared port into read register
    logic hiAddr;    // high port carries address
  } xmemCtl_t;
endpackage

// File: rtl/xmem_ctrl.sv
module xmem_ctrl
  import xmem_pkg::*;
#(
  parameter int CLKS_PER_MCYCLE = 6
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqWrite,
  input  logic     reqWide,
  output xmemCtl_t ctl,
  output logic     busy,
  output logic     done
);
  localparam int XFER_CLKS = 2 * CLKS_PER_MCYCLE;
  localparam int CNT_W = $clog2(XFER_CLKS);
  localparam logic [CNT_W-1:0] LAST      = CNT_W'(XFER_CLKS - 1);
  localparam logic [CNT_W-1:0] SECOND    = CNT_W'(CLKS_PER_MCYCLE);
  localparam logic [CNT_W-1:0] ALE_END   = CNT_W'(CLKS_PER_MCYCLE / 2);
  localparam logic [CNT_W-1:0] STB_FIRST = CNT_W'(CLKS_PER_MCYCLE + 1);
  localparam logic [CNT_W-1:0] STB_LAST  = CNT_W'(XFER_CLKS - 2);

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic             isWrite;
  logic             isWide;
  logic             doneQ;
  logic             accept;
  logic             inStb;

  assign accept = reqValid && !active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      cnt     <= '0;
      isWrite <= 1'b0;
      isWide  <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (accept) begin
        active  <= 1'b1;
        cnt     <= '0;
        isWrite <= reqWrite;
        isWide  <= reqWide;
      end else if (active) begin
        if (cnt == LAST) begin
          active <= 1'b0;
          doneQ  <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign inStb = active && (cnt >= STB_FIRST) && (cnt <= STB_LAST);

  always_comb begin
    ctl.load     = accept;
    ctl.inXfer   = active;
    ctl.showAddr = active && (cnt < SECOND);
    ctl.showData = active && isWrite && (cnt >= SECOND);
    ctl.ale      = active && (cnt < ALE_END);
    ctl.rdAct    = inStb && !isWrite;
    ctl.wrAct    = inStb && isWrite;
    ctl.capture  = inStb && !isWrite && (cnt == STB_LAST);
    ctl.hiAddr   = active && isWide;
  end

  assign busy = active;
  assign done = doneQ;

  // R2
  xfer_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && cnt == LAST) |=> (!active && doneQ));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && cnt != LAST) |=> (active && isWrite == $past(isWrite) && isWide == $past(isWide)));
endmodule

// File: rtl/xmem_dp.sv
module xmem_dp
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  xmemCtl_t          ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqAcc,
  input  logic [ADDR_W-DATA_W-1:0] hiPortIo,
  input  logic              rdPinIo,
  input  logic              wrPinIo,
  input  logic [DATA_W-1:0] adIn,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic              ale,
  output logic [ADDR_W-DATA_W-1:0] hiOut,
  output logic              rdN,
  output logic              wrN
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] accQ;
  logic [DATA_W-1:0] rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      accQ  <= '0;
    end else if (ctl.load) begin
      addrQ <= reqAddr;
      accQ  <= reqAcc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdQ <= '0;
    else if (ctl.capture) rdQ <= adIn;
  end

  assign rdData = rdQ;
  assign adOut  = ctl.showAddr ? addrQ[DATA_W-1:0] : accQ;
  assign adOe   = ctl.showAddr || ctl.showData;
  assign ale    = ctl.ale;
  assign hiOut  = ctl.hiAddr ? addrQ[ADDR_W-1:DATA_W] : hiPortIo;
  assign rdN    = ctl.inXfer ? !ctl.rdAct : rdPinIo;
  assign wrN    = ctl.inXfer ? !ctl.wrAct : wrPinIo;

  // R6
  rd_tristate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.inXfer && !rdN) |-> !adOe);

  // R3
  ale_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ale) |-> (adOe && $stable(adOut)));

  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.inXfer && $past(ctl.inXfer) && $rose(wrN)) |-> (adOe && $stable(adOut)));

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(rdData));

  // R6 R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.inXfer |-> (rdN || wrN));

  if (HI_W < 1) begin : g_badWidth
    initial $error("address must be wider than data");
  end
endmodule

// File: rtl/xmem_access_unit.sv
module xmem_access_unit
  import xmem_pkg::*;
#(
  parameter int CLKS_PER_MCYCLE = 6,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqWide,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqAcc,
  input  logic [ADDR_W-DATA_W-1:0] hiPortIo,
  input  logic              rdPinIo,
  input  logic              wrPinIo,
  input  logic [DATA_W-1:0] adIn,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic              ale,
  output logic [ADDR_W-DATA_W-1:0] hiOut,
  output logic              rdN,
  output logic              wrN
);
  xmemCtl_t ctl;

  xmem_ctrl #(.CLKS_PER_MCYCLE(CLKS_PER_MCYCLE)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWide(reqWide), .ctl(ctl), .busy(busy), .done(done)
  );

  xmem_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqAcc(reqAcc),
    .hiPortIo(hiPortIo), .rdPinIo(rdPinIo), .wrPinIo(wrPinIo), .adIn(adIn),
    .rdData(rdData), .adOut(adOut), .adOe(adOe), .ale(ale), .hiOut(hiOut),
    .rdN(rdN), .wrN(wrN)
  );
endmodule

// File: tb/xmem_access_unit_test.sv
module xmem_access_unit_test;
  localparam int C = 6;
  localparam int XC = 2 * C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqWide = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqAcc = '0;
  logic [7:0]  hiPortIo = 8'h3C;
  logic rdPinIo = 1'b1, wrPinIo = 1'b0;
  logic [7:0]  adIn;
  logic busy, done, adOe, ale, rdN, wrN;
  logic [7:0] rdData, adOut, hiOut;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [7:0] latchLo = '0;
  logic [15:0] wrAddrSeen = '0;
  logic [7:0]  wrDataSeen = '0;
  int wrCount = 0;
  logic [7:0] lastRd = '0;

  always #4 clk = ~clk;

  xmem_access_unit #(.CLKS_PER_MCYCLE(C)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWide(reqWide), .reqAddr(reqAddr), .reqAcc(reqAcc), .hiPortIo(hiPortIo),
    .rdPinIo(rdPinIo), .wrPinIo(wrPinIo), .adIn(adIn), .busy(busy), .done(done),
    .rdData(rdData), .adOut(adOut), .adOe(adOe), .ale(ale), .hiOut(hiOut),
    .rdN(rdN), .wrN(wrN)
  );

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return 8'(a[7:0] * 3) ^ a[15:8] ^ 8'h5A;
  endfunction

  // bench memory model: external latch and store capture
  always @(negedge ale) latchLo <= adOut;
  assign adIn = !rdN ? memByte({hiOut, latchLo}) : 8'hEE;
  always @(posedge wrN) if (busy) begin
    wrAddrSeen <= {hiOut, latchLo};
    wrDataSeen <= adOut;
    wrCount    <= wrCount + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit w, input bit wd, input logic [15:0] a,
                      input logic [7:0] d, input logic [7:0] ph, input bit junk);
    logic [7:0] hiExp;
    int wrBefore;
    hiExp = wd ? a[15:8] : ph;
    wrBefore = wrCount;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqWide = wd; reqAddr = a; reqAcc = d;
    hiPortIo = ph;
    for (int k = 0; k < XC; k++) begin
      @(negedge clk);
      if (junk) begin
        reqAddr = ~a; reqAcc = ~d; reqWrite = !w; reqWide = !wd;
        rdPinIo = !rdPinIo; wrPinIo = !wrPinIo;
      end else begin
        reqValid = 1'b0;
      end
      chk("R2 busy", busy, 1); chk("R2 done low", done, 0);
      chk("R3 ale", ale, k < C/2);
      chk("R3/R6/R8 adOe", adOe, (k < C) || w);
      if (k < C) chk("R3/R10 adOut addr", adOut, a[7:0]);
      else if (w) chk("R8/R10 adOut data", adOut, d);
      if (wd) chk("R4 hiOut", hiOut, hiExp);
      else    chk("R5 hiOut", hiOut, hiExp);
      chk("R6/R9 rdN", rdN, !(!w && k >= C+1 && k <= XC-2));
      chk("R8/R9 wrN", wrN, !(w && k >= C+1 && k <= XC-2));
    end
    @(negedge clk);
    chk("R2 busy end", busy, 0); chk("R2 done", done, 1);
    chk("R9 rdN idle", rdN, rdPinIo); chk("R9 wrN idle", wrN, wrPinIo);
    if (!w) begin
      lastRd = memByte({hiExp, a[7:0]});
      chk("R7 rdData", rdData, lastRd);
      chk("R6 no store", wrCount, wrBefore);
    end else begin
      chk("R7 rdData held", rdData, lastRd);
      chk("R8 store count", wrCount, wrBefore + 1);
      chk("R8 store addr", wrAddrSeen, {hiExp, a[7:0]});
      chk("R8 store data", wrDataSeen, d);
    end
    reqValid = 1'b0;
    @(negedge clk);
    chk("R2 done one clock", done, 0);
    chk("R7 rdData stable", rdData, lastRd);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    chk("R1 ale", ale, 0); chk("R1 adOe", adOe, 0);
    chk("R1 rdN", rdN, rdPinIo); chk("R1 wrN", wrN, wrPinIo);
    chk("R1 hiOut", hiOut, 8'h3C);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 busy after", busy, 0); chk("R9 wrN idle", wrN, 0);
    rdPinIo = 1'b0; wrPinIo = 1'b1;
    @(negedge clk);
    chk("R9 rdN io", rdN, 0); chk("R9 wrN io", wrN, 1);
    for (int i = 0; i < 256; i++)
      xfer(1'b0, 1'b0, {8'(i * 7), 8'(i)}, 8'(i + 9), 8'(255 - i), (i % 5) == 0);
    for (int i = 0; i < 256; i++)
      xfer(1'b1, 1'b1, {8'(i), 8'(i * 13 + 1)}, 8'(i * 11), 8'(i ^ 8'hA5), (i % 7) == 3);
    for (int i = 0; i < 64; i++) begin
      xfer(1'b1, 1'b0, {8'(i * 5), 8'(i * 3)}, 8'(i * 29), 8'(i * 2), (i % 4) == 1);
      xfer(1'b0, 1'b1, {8'(i * 9 + 4), 8'(i * 3)}, 8'h00, 8'(i), (i % 3) == 2);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule